// File: doc/BRIEF.md
# DRAM Read/Write Turnaround Scheduler

This block sits on the controller side of a DRAM interface and decides, cycle by cycle, which of a set of per-bank command requesters may issue. Each bank presents a valid flag and a two-bit command kind. The scheduler grants at most one bank per cycle. It keeps the bus in either a read or a write direction, and inserts a fixed turnaround wait whenever it changes direction. Timers stop one direction from holding the bus while the other direction has work waiting.

Row activates are spaced by a minimum number of cycles, and so are column commands (reads and writes). A refresh request is passed on to all banks as an ask. While the ask is raised, no bank command is granted. The refresh strobe is issued two cycles after the first cycle in which every bank grants consent. The scheduler carries no data.

Top module: `rw_turn_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, `dir_state` is 0 (read), `refresh_ask` and `refresh_fire` are low. The read hold timer starts expired, so a write that is pending while reads are also pending makes the scheduler leave read in the very next cycle.
- R2: `dir_state` encodes 0=read, 1=read-to-write wait, 2=write, 3=write-to-read wait. The read-to-write wait lasts RD_LAT-1 cycles, so write is entered RD_LAT cycles after the last read cycle.
- R3: The write-to-read wait lasts TWTR + ceil(CWL/NPH) + TCCD - 1 cycles.
- R4: When both directions stay pending, write is held for exactly WR_TIME cycles and read for exactly RD_TIME cycles before the scheduler enters the matching turnaround.
- R5: With no work pending in the other direction, the scheduler stays in its current direction indefinitely. With its own direction empty and the other direction pending, it leaves at once, whatever the timer holds.
- R6: Command kind 0 is an activate. Two granted activates are at least TRRD cycles apart.
- R7: Kinds 1 (read) and 2 (write) are column commands. Two granted column commands are at least TCCD cycles apart.
- R8: A one-cycle `refresh_req` raises `refresh_ask` from the next cycle. No bank is granted while the ask is high. `refresh_fire` pulses for one cycle, two cycles after the first cycle in which all `refresh_grant` bits are high with the ask raised. The ask drops in the cycle after the pulse.
- R9: At most one `bank_ready` bit is high per cycle, and only for a valid bank. The lowest-index eligible bank wins. Each bank's commands therefore leave in the order it presents them.
- R10: A read is granted only in direction 0 and a write only in direction 2. Nothing of kind 1 or 2 is granted in the two turnaround states. Activates and kind 3 (precharge) may be granted in any direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_valid | input | NB | Per-bank request valid |
| bank_kind | input | 2*NB | Per-bank command kind, two bits per bank (0 activate, 1 read, 2 write, 3 precharge) |
| bank_ready | output | NB | Per-bank grant, combinational from the inputs and the state |
| refresh_req | input | 1 | Refresh request pulse |
| refresh_ask | output | 1 | Refresh ask broadcast to all banks |
| refresh_grant | input | NB | Per-bank refresh consent |
| refresh_fire | output | 1 | One-cycle refresh command strobe |
| dir_state | output | 2 | Current direction or turnaround state |

## Verification
The bank grant is due in the same cycle as the request it answers. The direction, the ask and the fire strobe change only at the edge that closes the cycle in which their cause is seen. A turnaround's length is therefore counted from the first cycle the new state value appears to the first cycle it is gone. Inputs are applied just after the falling edge. Every output is compared one nanosecond later against a behavioural model that advances on the rising edge, so each comparison falls inside the cycle in which the result is due. Separate counters measure the run length of each direction state and the cycle gap between successive granted activates and between successive granted column commands, each directly against the parameters.

// File: rtl/rw_turn_pkg.sv
package rw_turn_pkg;

    typedef enum logic [1:0] {
        DIR_RD  = 2'd0,
        DIR_R2W = 2'd1,
        DIR_WR  = 2'd2,
        DIR_W2R = 2'd3
    } dir_e;

    typedef enum logic [1:0] {
        CMD_ACT = 2'd0,
        CMD_RD  = 2'd1,
        CMD_WR  = 2'd2,
        CMD_PRE = 2'd3
    } cmd_e;

    function automatic int unsigned ceil_div(int unsigned a, int unsigned b);
        return (a + b - 1) / b;
    endfunction

    // total cycles from the last write cycle to the first read cycle
    function automatic int unsigned w2r_total(int unsigned twtr, int unsigned cwl,
                                              int unsigned nph, int unsigned tccd);
        return twtr + ceil_div(cwl, nph) + tccd;
    endfunction

    // may a command of kind k leave now, given direction and spacing windows
    function automatic logic may_issue(cmd_e k, dir_e d, logic act_open, logic cas_open);
        case (k)
            CMD_ACT: return act_open;
            CMD_RD:  return cas_open && (d == DIR_RD);
            CMD_WR:  return cas_open && (d == DIR_WR);
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/rw_gap_timer.sv
module rw_gap_timer #(
    parameter int GAP = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic fire_i,
    output logic open_o
);
    localparam int W = (GAP < 2) ? 1 : $clog2(GAP);

    logic [W-1:0] wait_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q <= '0;
        end else if (fire_i) begin
            wait_q <= W'(GAP - 1);
        end else if (wait_q != '0) begin
            wait_q <= wait_q - W'(1);
        end
    end

    assign open_o = (wait_q == '0);
endmodule

// File: rtl/rw_dir_fsm.sv
module rw_dir_fsm
    import rw_turn_pkg::*;
#(
    parameter int RD_TIME = 32,
    parameter int WR_TIME = 16,
    parameter int R2W_LEN = 4,
    parameter int W2R_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_pend,
    input  logic wr_pend,
    output dir_e dir_o
);
    localparam int HMAX = (RD_TIME > WR_TIME) ? RD_TIME : WR_TIME;
    localparam int HW   = $clog2(HMAX + 1);
    localparam int TMAX = (R2W_LEN > W2R_LEN) ? R2W_LEN : W2R_LEN;
    localparam int TW   = $clog2(TMAX + 1);

    dir_e          dir_q;
    logic [HW-1:0] hold_q;
    logic [TW-1:0] turn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= DIR_RD;
            hold_q <= '0;
            turn_q <= '0;
        end else begin
            case (dir_q)
                DIR_RD: begin
                    if (wr_pend && (hold_q == '0 || !rd_pend)) begin
                        dir_q  <= DIR_R2W;
                        turn_q <= TW'(R2W_LEN - 1);
                    end else if (hold_q != '0) begin
                        hold_q <= hold_q - HW'(1);
                    end
                end
                DIR_R2W: begin
                    if (turn_q == '0) begin
                        dir_q  <= DIR_WR;
                        hold_q <= HW'(WR_TIME - 1);
                    end else begin
                        turn_q <= turn_q - TW'(1);
                    end
                end
                DIR_WR: begin
                    if (rd_pend && (hold_q == '0 || !wr_pend)) begin
                        dir_q  <= DIR_W2R;
                        turn_q <= TW'(W2R_LEN - 1);
                    end else if (hold_q != '0) begin
                        hold_q <= hold_q - HW'(1);
                    end
                end
                default: begin
                    if (turn_q == '0) begin
                        dir_q  <= DIR_RD;
                        hold_q <= HW'(RD_TIME - 1);
                    end else begin
                        turn_q <= turn_q - TW'(1);
                    end
                end
            endcase
        end
    end

    assign dir_o = dir_q;
endmodule

// File: rtl/rw_refresh_gate.sv
module rw_refresh_gate #(
    parameter int NB = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_i,
    input  logic [NB-1:0] grant_i,
    output logic          ask_o,
    output logic          fire_o
);
    logic pend_q, stage_q, fire_q;
    logic all_ok;

    assign all_ok = &grant_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            stage_q <= 1'b0;
            fire_q  <= 1'b0;
        end else begin
            pend_q  <= fire_q ? 1'b0 : (pend_q | req_i);
            stage_q <= pend_q && all_ok && !stage_q && !fire_q;
            fire_q  <= stage_q;
        end
    end

    assign ask_o  = pend_q;
    assign fire_o = fire_q;
endmodule

// File: rtl/rw_pick.sv
module rw_pick #(
    parameter int NB = 8
) (
    input  logic [NB-1:0] elig_i,
    output logic [NB-1:0] grant_o
);
    always_comb begin
        logic found;
        found   = 1'b0;
        grant_o = '0;
        for (int i = 0; i < NB; i++) begin
            if (elig_i[i] && !found) begin
                grant_o[i] = 1'b1;
                found      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rw_turn_sched.sv
module rw_turn_sched
    import rw_turn_pkg::*;
#(
    parameter int NB      = 8,
    parameter int TRRD    = 4,
    parameter int TCCD    = 1,
    parameter int RD_LAT  = 5,
    parameter int TWTR    = 2,
    parameter int CWL     = 3,
    parameter int NPH     = 2,
    parameter int RD_TIME = 32,
    parameter int WR_TIME = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NB-1:0]   bank_valid,
    input  logic [2*NB-1:0] bank_kind,
    output logic [NB-1:0]   bank_ready,
    input  logic            refresh_req,
    output logic            refresh_ask,
    input  logic [NB-1:0]   refresh_grant,
    output logic            refresh_fire,
    output logic [1:0]      dir_state
);
    localparam int R2W_LEN = RD_LAT - 1;
    localparam int W2R_LEN = int'(w2r_total(TWTR, CWL, NPH, TCCD)) - 1;

    dir_e          dir;
    logic          act_open, cas_open;
    logic [NB-1:0] is_act, is_cas, is_rd, is_wr, elig;
    logic          act_fire, cas_fire;

    for (genvar g = 0; g < NB; g++) begin : g_bank
        cmd_e k;
        assign k         = cmd_e'(bank_kind[2*g +: 2]);
        assign is_act[g] = bank_valid[g] && (k == CMD_ACT);
        assign is_rd[g]  = bank_valid[g] && (k == CMD_RD);
        assign is_wr[g]  = bank_valid[g] && (k == CMD_WR);
        assign is_cas[g] = is_rd[g] || is_wr[g];
        assign elig[g]   = bank_valid[g] && !refresh_ask
                           && may_issue(k, dir, act_open, cas_open);
    end

    rw_pick #(.NB(NB)) pick_i (
        .elig_i  (elig),
        .grant_o (bank_ready)
    );

    assign act_fire = |(bank_ready & is_act);
    assign cas_fire = |(bank_ready & is_cas);

    rw_gap_timer #(.GAP(TRRD)) act_gap_i (
        .clk    (clk),
        .rst    (rst),
        .fire_i (act_fire),
        .open_o (act_open)
    );

    rw_gap_timer #(.GAP(TCCD)) cas_gap_i (
        .clk    (clk),
        .rst    (rst),
        .fire_i (cas_fire),
        .open_o (cas_open)
    );

    rw_dir_fsm #(
        .RD_TIME (RD_TIME),
        .WR_TIME (WR_TIME),
        .R2W_LEN (R2W_LEN),
        .W2R_LEN (W2R_LEN)
    ) dir_i (
        .clk     (clk),
        .rst     (rst),
        .rd_pend (|is_rd),
        .wr_pend (|is_wr),
        .dir_o   (dir)
    );

    rw_refresh_gate #(.NB(NB)) ref_i (
        .clk     (clk),
        .rst     (rst),
        .req_i   (refresh_req),
        .grant_i (refresh_grant),
        .ask_o   (refresh_ask),
        .fire_o  (refresh_fire)
    );

    assign dir_state = dir;
endmodule

// File: rtl/rw_turn_sched_chk.sv
module rw_turn_sched_chk #(
    parameter int NB   = 8,
    parameter int TRRD = 4,
    parameter int TCCD = 1
) (
    input logic            clk,
    input logic            rst,
    input logic [NB-1:0]   bank_valid,
    input logic [2*NB-1:0] bank_kind,
    input logic [NB-1:0]   bank_ready,
    input logic            refresh_ask,
    input logic            refresh_fire,
    input logic [1:0]      dir_state
);
    localparam int unsigned SAT = 32'h0000_FFFF;

    logic act_acc, rd_acc, wr_acc;
    int unsigned since_act, since_cas;

    always_comb begin
        act_acc = 1'b0;
        rd_acc  = 1'b0;
        wr_acc  = 1'b0;
        for (int i = 0; i < NB; i++) begin
            if (bank_ready[i] && bank_valid[i]) begin
                if (bank_kind[2*i +: 2] == 2'd0) act_acc = 1'b1;
                if (bank_kind[2*i +: 2] == 2'd1) rd_acc  = 1'b1;
                if (bank_kind[2*i +: 2] == 2'd2) wr_acc  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            since_act <= SAT;
            since_cas <= SAT;
        end else begin
            since_act <= act_acc ? 1 : ((since_act < SAT) ? since_act + 1 : since_act);
            since_cas <= (rd_acc || wr_acc) ? 1 : ((since_cas < SAT) ? since_cas + 1 : since_cas);
        end
    end

    assert_reset_read_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (dir_state == 2'd0 && !refresh_ask && !refresh_fire));

    assert_write_via_wait_R2: assert property (@(posedge clk) disable iff (rst)
        (dir_state == 2'd2 && $past(dir_state) != 2'd2) |-> $past(dir_state) == 2'd1);

    assert_read_via_wait_R3: assert property (@(posedge clk) disable iff (rst)
        (dir_state == 2'd0 && $past(dir_state) != 2'd0) |-> $past(dir_state) == 2'd3);

    assert_act_spacing_R6: assert property (@(posedge clk) disable iff (rst)
        act_acc |-> since_act >= TRRD);

    assert_cas_spacing_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_acc || wr_acc) |-> since_cas >= TCCD);

    assert_quiet_on_ask_R8: assert property (@(posedge clk) disable iff (rst)
        refresh_ask |-> bank_ready == '0);

    assert_fire_single_R8: assert property (@(posedge clk) disable iff (rst)
        refresh_fire |=> !refresh_fire);

    assert_fire_with_ask_R8: assert property (@(posedge clk) disable iff (rst)
        refresh_fire |-> refresh_ask);

    assert_one_grant_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_ready) && ((bank_ready & ~bank_valid) == '0));

    assert_read_dir_R10: assert property (@(posedge clk) disable iff (rst)
        rd_acc |-> dir_state == 2'd0);

    assert_write_dir_R10: assert property (@(posedge clk) disable iff (rst)
        wr_acc |-> dir_state == 2'd2);
endmodule

bind rw_turn_sched rw_turn_sched_chk #(
    .NB   (NB),
    .TRRD (TRRD),
    .TCCD (TCCD)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .bank_valid   (bank_valid),
    .bank_kind    (bank_kind),
    .bank_ready   (bank_ready),
    .refresh_ask  (refresh_ask),
    .refresh_fire (refresh_fire),
    .dir_state    (dir_state)
);

// File: tb/rw_turn_sched_tb_top.sv
`timescale 1ns/1ps
module rw_turn_sched_tb_top;
    localparam int NB      = 6;
    localparam int TRRD    = 6;
    localparam int TCCD    = 3;
    localparam int RD_LAT  = 5;
    localparam int TWTR    = 2;
    localparam int CWL     = 3;
    localparam int NPH     = 2;
    localparam int RD_TIME = 32;
    localparam int WR_TIME = 16;
    localparam int W2R_TOTAL = TWTR + (CWL + NPH - 1) / NPH + TCCD;
    localparam int QD = 64;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NB-1:0]   bank_valid = '0;
    logic [2*NB-1:0] bank_kind = '0;
    logic [NB-1:0]   bank_ready;
    logic            refresh_req = 1'b0;
    logic            refresh_ask;
    logic [NB-1:0]   refresh_grant = '0;
    logic            refresh_fire;
    logic [1:0]      dir_state;

    always #2 clk = ~clk;

    rw_turn_sched #(
        .NB(NB), .TRRD(TRRD), .TCCD(TCCD), .RD_LAT(RD_LAT), .TWTR(TWTR),
        .CWL(CWL), .NPH(NPH), .RD_TIME(RD_TIME), .WR_TIME(WR_TIME)
    ) dut_i (
        .clk(clk), .rst(rst), .bank_valid(bank_valid), .bank_kind(bank_kind),
        .bank_ready(bank_ready), .refresh_req(refresh_req), .refresh_ask(refresh_ask),
        .refresh_grant(refresh_grant), .refresh_fire(refresh_fire), .dir_state(dir_state)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // per-bank command queues
    int bq [NB][QD];
    int bh [NB];
    int bt [NB];

    // reference model state
    int m_dir = 0, m_hold = 0, m_turn = 0, m_act = 0, m_cas = 0;
    int m_pend = 0, m_stg = 0, m_fire = 0;
    int m_fires = 0;

    // drive controls
    logic            req_drv = 1'b0;
    logic [NB-1:0]   gnt_drv = '0;

    // directed observation state
    int cyc = 0;
    int prev_dir = 0, run_len = 0;
    bit chk_runs = 0, skip_first = 0;
    int last_act = -1000, last_cas = -1000;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", what, act, exp, cyc);
        end
    endtask

    task automatic push(input int b, input int k);
        bq[b][bt[b]] = k;
        bt[b]++;
    endtask

    function automatic bit q_busy(input int b);
        return bh[b] != bt[b];
    endfunction

    function automatic bit any_busy();
        for (int b = 0; b < NB; b++) if (q_busy(b)) return 1;
        return 0;
    endfunction

    task automatic step();
        int exp_ready, rdp, wrp, k, hit, acc_act, acc_cas;
        @(negedge clk);
        for (int b = 0; b < NB; b++) begin
            bank_valid[b] = q_busy(b);
            bank_kind[2*b +: 2] = q_busy(b) ? 2'(bq[b][bh[b]]) : 2'd0;
        end
        refresh_req   = req_drv;
        refresh_grant = gnt_drv;
        #1;
        // model outputs for this cycle
        rdp = 0; wrp = 0; exp_ready = 0; hit = 0; acc_act = 0; acc_cas = 0;
        for (int b = 0; b < NB; b++) begin
            if (q_busy(b)) begin
                k = bq[b][bh[b]];
                if (k == 1) rdp = 1;
                if (k == 2) wrp = 1;
                if (!hit && m_pend == 0 &&
                    ((k == 0 && m_act == 0) || k == 3 ||
                     (k == 1 && m_dir == 0 && m_cas == 0) ||
                     (k == 2 && m_dir == 2 && m_cas == 0))) begin
                    hit = 1;
                    exp_ready = 1 << b;
                    if (k == 0) acc_act = 1;
                    if (k == 1 || k == 2) acc_cas = 1;
                end
            end
        end
        check(int'(bank_ready) == exp_ready, "R9,R10,R6,R7,R8 bank_ready", int'(bank_ready), exp_ready);
        check(int'(dir_state) == m_dir, "R2,R3,R4,R5 dir_state", int'(dir_state), m_dir);
        check(int'(refresh_ask) == m_pend, "R8 refresh_ask", int'(refresh_ask), m_pend);
        check(int'(refresh_fire) == m_fire, "R8 refresh_fire", int'(refresh_fire), m_fire);
        check($countones(bank_ready) <= 1, "R9 single grant", $countones(bank_ready), 1);

        // directed: spacing observed at the ports
        for (int b = 0; b < NB; b++) begin
            if (bank_ready[b] && bank_valid[b]) begin
                if (bank_kind[2*b +: 2] == 2'd0) begin
                    check(cyc - last_act >= TRRD, "R6 activate gap", cyc - last_act, TRRD);
                    last_act = cyc;
                end
                if (bank_kind[2*b +: 2] == 2'd1 || bank_kind[2*b +: 2] == 2'd2) begin
                    check(cyc - last_cas >= TCCD, "R7 column gap", cyc - last_cas, TCCD);
                    last_cas = cyc;
                end
            end
        end

        // directed: run lengths of the direction states
        if (int'(dir_state) != prev_dir) begin
            if (prev_dir == 1)
                check(run_len == RD_LAT - 1, "R2 read-to-write wait length", run_len, RD_LAT - 1);
            if (prev_dir == 3)
                check(run_len == W2R_TOTAL - 1, "R3 write-to-read wait length", run_len, W2R_TOTAL - 1);
            if (chk_runs && prev_dir == 2 && q_busy(2) && q_busy(3))
                check(run_len == WR_TIME, "R4 write hold length", run_len, WR_TIME);
            if (chk_runs && prev_dir == 0 && q_busy(2) && q_busy(3)) begin
                if (!skip_first)
                    check(run_len == RD_TIME, "R4 read hold length", run_len, RD_TIME);
                skip_first = 0;
            end
            prev_dir = int'(dir_state);
            run_len = 1;
        end else begin
            run_len++;
        end

        @(posedge clk);
        // model state update
        if (acc_act) m_act = TRRD - 1; else if (m_act > 0) m_act--;
        if (acc_cas) m_cas = TCCD - 1; else if (m_cas > 0) m_cas--;
        case (m_dir)
            0: if (wrp && (m_hold == 0 || !rdp)) begin m_dir = 1; m_turn = RD_LAT - 2; end
               else if (m_hold > 0) m_hold--;
            1: if (m_turn == 0) begin m_dir = 2; m_hold = WR_TIME - 1; end else m_turn--;
            2: if (rdp && (m_hold == 0 || !wrp)) begin m_dir = 3; m_turn = W2R_TOTAL - 2; end
               else if (m_hold > 0) m_hold--;
            default: if (m_turn == 0) begin m_dir = 0; m_hold = RD_TIME - 1; end else m_turn--;
        endcase
        begin
            int n_pend, n_stg;
            n_pend = (m_fire != 0) ? 0 : ((m_pend != 0 || req_drv) ? 1 : 0);
            n_stg  = (m_pend != 0 && (&gnt_drv) && m_stg == 0 && m_fire == 0) ? 1 : 0;
            m_fire = m_stg;
            m_stg  = n_stg;
            m_pend = n_pend;
            if (m_fire != 0) m_fires++;
        end
        for (int b = 0; b < NB; b++) if (exp_ready[b]) bh[b]++;
        cyc++;
    endtask

    task automatic run_out(input int limit);
        int n;
        n = 0;
        while (any_busy() && n < limit) begin
            step();
            n++;
        end
        check(!any_busy(), "R9 all queued commands granted in order", int'(any_busy()), 0);
        repeat (4) step();
    endtask

    initial begin
        for (int b = 0; b < NB; b++) begin bh[b] = 0; bt[b] = 0; end
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check(dir_state == 2'd0, "R1 dir in reset", int'(dir_state), 0);
        check(refresh_ask == 1'b0, "R1 ask in reset", int'(refresh_ask), 0);
        check(refresh_fire == 1'b0, "R1 fire in reset", int'(refresh_fire), 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) step();

        // R1, R4: both directions busy; first read hold already expired
        chk_runs = 1; skip_first = 1;
        for (int i = 0; i < 40; i++) begin push(2, 1); push(3, 2); end
        step();
        check(dir_state == 2'd0, "R1 still read on first busy cycle", int'(dir_state), 0);
        step();
        check(dir_state == 2'd1, "R1 expired hold leaves read at once", int'(dir_state), 1);
        run_out(3000);
        chk_runs = 0;

        // R6, R9: activates and precharges from several banks
        for (int b = 0; b < 4; b++) begin push(b, 0); push(b, 0); push(b, 3); end
        run_out(500);

        // R10, R9: mixed per-bank sequences
        push(0, 0); push(0, 2); push(0, 2); push(0, 3);
        push(1, 0); push(1, 1); push(1, 1); push(1, 3);
        push(4, 0); push(4, 2); push(4, 3); push(4, 0); push(4, 1); push(4, 3);
        push(5, 0); push(5, 1); push(5, 2); push(5, 1);
        run_out(1000);

        // R8: refresh with staggered consent while traffic waits
        for (int i = 0; i < 4; i++) begin push(1, 1); push(2, 0); end
        step();
        req_drv = 1'b1;
        step();
        req_drv = 1'b0;
        step();
        check(refresh_ask == 1'b1, "R8 ask follows request", int'(refresh_ask), 1);
        for (int b = 0; b < NB; b++) begin
            gnt_drv[b] = 1'b1;
            step();
            step();
        end
        begin
            int w;
            w = 0;
            while (m_fires == 0 && w < 10) begin step(); w++; end
        end
        check(m_fires == 1, "R8 refresh strobe issued", m_fires, 1);
        step();
        gnt_drv = '0;
        run_out(500);

        // R5: only writes, then idle; direction must stay write
        for (int i = 0; i < 5; i++) push(1, 2);
        run_out(500);
        repeat (40) step();
        check(dir_state == 2'd2, "R5 stays in write with no reads", int'(dir_state), 2);
        push(0, 1);
        run_out(200);
        check(dir_state == 2'd0, "R5 reads alone pull back to read", int'(dir_state), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule